// File: doc/BRIEF.md
# SDRAM Column Burst Engine with Clock Suspend

This block is the device-side sequencer for one column burst inside a synchronous DRAM. It takes already decoded READ and WRITE commands together with a start column. It walks the column address through a burst whose length and ordering come from a mode word it holds. For reads it delivers array data on a data output after a programmable CAS latency. For writes it raises a write strobe toward the internal array, one column per internal cycle.

The clock-enable pin is sampled on every rising edge, and each low sample freezes the following internal cycle. While a burst is in flight this freeze acts as clock suspend. The column counter stops, commands and write strobes are dropped, and read data already on the output is held. With no burst or read data in flight, a low sample puts the block into power-down, which discards commands until the pin is sampled high again. A mode bit can limit every write to a single column while reads keep the programmed length.

Top module: `sdram_burst_engine`

## Requirements
- R1: The mode word field in bits [2:0] selects the burst length: 0 gives 1, 1 gives 2, 2 gives 4, 3 gives 8, and other codes give 1. An accepted command puts its first column on `col_addr` in the cycle after its edge, and each unsuspended edge after that moves to the next column until the burst is complete.
- R2: Mode bit 3 selects the ordering inside the aligned block of burst-length columns. When it is 0 the order is sequential: the low offset is (start + i) modulo the length. When it is 1 the order is interleaved: the low offset is start XOR i. The column bits above the block are taken from the start column.
- R3: Mode bits [5:4] give the CAS latency: 3 selects 3 cycles and any other value selects 2. Read beat i appears on `dq_out` with `rd_oe` high in the cycle after edge k+CL+i, where k is the command edge and no edge is suspended.
- R4: When `cke` is sampled low on an edge, the next edge is suspended, and `col_addr` and the burst position do not change across it.
- R5: A READ, WRITE or mode load present at a suspended edge is ignored. `wr_stb` is low in every cycle that ends in a suspended edge.
- R6: Across a suspended edge, `rd_oe` and `dq_out` keep their values.
- R7: When `cke` is sampled high, the following edge runs normally. Each suspended edge delays the remaining columns and the read data by exactly one cycle, and no beat is lost.
- R8: When mode bit 6 is 1, a WRITE strobes exactly one column, its start column, whatever the burst length.
- R9: When mode bit 6 is 1, READs still use the programmed burst length and ordering.
- R10: When `cke` is sampled low while no burst, no read data and no accepted command are in flight, `pd_active` goes high in the cycle after that edge. Commands are ignored until `cke` is sampled high, and `pd_active` is low after that edge.
- R11: A READ or WRITE accepted while a burst is running ends the old burst, and the new command's first column appears in the next cycle.
- R12: After reset, `rd_oe`, `wr_stb` and `pd_active` are low, the burst length is 1 with sequential order, the latency is 2 and single-column writes are off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cke | input | 1 | Clock-enable pin, sampled on every rising edge |
| mode_load | input | 1 | Loads `mode_word` at an unsuspended edge |
| mode_word | input | 7 | [2:0] length code, [3] interleave, [5:4] CAS latency, [6] single-column write |
| cmd_rd | input | 1 | Decoded READ command; wins over `cmd_wr` |
| cmd_wr | input | 1 | Decoded WRITE command |
| cmd_col | input | COL_W | Start column of the command |
| arr_rdata | input | DATA_W | Array read data for the column on `col_addr` |
| col_addr | output | COL_W | Current burst column |
| wr_stb | output | 1 | Array write strobe for `col_addr` at the coming edge |
| rd_oe | output | 1 | Read data output enable |
| dq_out | output | DATA_W | Read data output |
| pd_active | output | 1 | Block is in power-down |

## Verification
Two events can fall on one edge. A command can arrive on the same edge that samples `cke` low, and in that case it is accepted but its second column is frozen. A command can also arrive on an edge that an earlier low sample has suspended, and in that case it must be dropped. The bench provokes both with a per-edge mask of low `cke` samples, and it drives a conflicting WRITE with a different column into every suspended edge. Expected columns and read data come from a count of internal cycles that the bench keeps itself. Any absorbed command, lost beat or extra beat therefore shows up as a wrong column, strobe or data value.

// File: rtl/sbe_pkg.sv
package sbe_pkg;

    localparam int MODE_W  = 7;
    localparam int CL_MAX  = 3;
    localparam int OFF_W   = 3;   // offset bits inside the largest burst
    localparam int LEN_W   = 4;   // holds a burst length up to 8

    typedef enum logic [1:0] {
        PH_RUN,
        PH_SUSPEND,
        PH_PWRDN
    } phase_e;

    typedef struct packed {
        logic [LEN_W-1:0] blen;
        logic             ilv;
        logic [1:0]       cl;
        logic             wsingle;
    } mode_t;

    typedef struct packed {
        logic             active;
        logic             rd;
        logic             ilv;
        logic [LEN_W-1:0] len;
        logic [OFF_W-1:0] low;
        logic [OFF_W-1:0] idx;
    } burst_t;

    function automatic mode_t decode_mode(input logic [MODE_W-1:0] w);
        mode_t m;
        case (w[2:0])
            3'd1:    m.blen = 4'd2;
            3'd2:    m.blen = 4'd4;
            3'd3:    m.blen = 4'd8;
            default: m.blen = 4'd1;
        endcase
        m.ilv     = w[3];
        m.cl      = (w[5:4] == 2'd3) ? 2'd3 : 2'd2;
        m.wsingle = w[6];
        return m;
    endfunction

    function automatic logic [OFF_W-1:0] beat_off(
        input logic [OFF_W-1:0] low,
        input logic [OFF_W-1:0] idx,
        input logic [OFF_W-1:0] mask,
        input logic             ilv
    );
        if (ilv)
            return (low ^ idx) & mask;
        return (low + idx) & mask;
    endfunction

endpackage

// File: rtl/sbe_cke_ctrl.sv
module sbe_cke_ctrl
    import sbe_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   cke,
    input  logic   busy,
    input  logic   cmd_taken,
    output logic   ien,
    output phase_e phase
);

    logic cke_q;

    // A low sample on this edge freezes the next internal edge.
    always_ff @(posedge clk) begin
        if (rst) begin
            cke_q <= 1'b1;
            phase <= PH_RUN;
        end else begin
            cke_q <= cke;
            if (cke)
                phase <= PH_RUN;
            else if (busy || cmd_taken)
                phase <= PH_SUSPEND;
            else
                phase <= PH_PWRDN;
        end
    end

    assign ien = cke_q;

endmodule

// File: rtl/sbe_col_gen.sv
module sbe_col_gen
    import sbe_pkg::*;
#(
    parameter int COL_W = 9
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ien,
    input  logic             start,
    input  logic             start_rd,
    input  logic [COL_W-1:0] start_col,
    input  mode_t            mode,
    output logic [COL_W-1:0] col,
    output logic             active,
    output logic             is_rd
);

    burst_t           b_q;
    logic [COL_W-1:0] base_q;
    logic [OFF_W-1:0] mask;
    logic             last_beat;

    assign mask      = OFF_W'(b_q.len - LEN_W'(1));
    assign last_beat = ({1'b0, b_q.idx} == (b_q.len - LEN_W'(1)));

    always_ff @(posedge clk) begin
        if (rst) begin
            b_q    <= '0;
            base_q <= '0;
        end else if (start) begin
            // New command wins over any burst in flight.
            b_q.active <= 1'b1;
            b_q.rd     <= start_rd;
            b_q.ilv    <= mode.ilv;
            b_q.len    <= (!start_rd && mode.wsingle) ? LEN_W'(1) : mode.blen;
            b_q.low    <= start_col[OFF_W-1:0];
            b_q.idx    <= '0;
            base_q     <= start_col;
        end else if (ien && b_q.active) begin
            if (last_beat)
                b_q.active <= 1'b0;
            else
                b_q.idx <= b_q.idx + OFF_W'(1);
        end
    end

    assign col    = {base_q[COL_W-1:OFF_W],
                     (base_q[OFF_W-1:0] & ~mask) | beat_off(b_q.low, b_q.idx, mask, b_q.ilv)};
    assign active = b_q.active;
    assign is_rd  = b_q.rd;

    // Frozen edge: the column must not move.
    assert_col_hold_R4: assert property (@(posedge clk) disable iff (rst)
        !ien |=> $stable(col));

    // Burst position never runs past the programmed length.
    assert_idx_in_range_R1: assert property (@(posedge clk) disable iff (rst)
        b_q.active |-> ({1'b0, b_q.idx} < b_q.len));

endmodule

// File: rtl/sbe_lat_pipe.sv
module sbe_lat_pipe
    import sbe_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int DEPTH  = CL_MAX
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ien,
    input  logic              cap_vld,
    input  logic [DATA_W-1:0] cap_data,
    input  logic [1:0]        cl,
    output logic              oe,
    output logic [DATA_W-1:0] dq,
    output logic              busy
);

    logic              vld_q [DEPTH];
    logic [DATA_W-1:0] dat_q [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_stage
        if (g == 0) begin : g_head
            always_ff @(posedge clk) begin
                if (rst) begin
                    vld_q[0] <= 1'b0;
                    dat_q[0] <= '0;
                end else if (ien) begin
                    vld_q[0] <= cap_vld;
                    dat_q[0] <= cap_data;
                end
            end
        end else begin : g_tail
            always_ff @(posedge clk) begin
                if (rst) begin
                    vld_q[g] <= 1'b0;
                    dat_q[g] <= '0;
                end else if (ien) begin
                    vld_q[g] <= vld_q[g-1];
                    dat_q[g] <= dat_q[g-1];
                end
            end
        end
    end

    // Tap chosen by latency: stage CL-1 drives the pins.
    always_comb begin
        oe   = 1'b0;
        dq   = '0;
        busy = 1'b0;
        for (int i = 0; i < DEPTH; i++) begin
            busy = busy | vld_q[i];
            if (i == int'(cl) - 1) begin
                oe = vld_q[i];
                dq = dat_q[i];
            end
        end
    end

    // Suspended edge keeps the driven read data in place.
    assert_dq_hold_R6: assert property (@(posedge clk) disable iff (rst)
        !ien |=> ($stable(dq) && $stable(oe)));

endmodule

// File: rtl/sdram_burst_engine.sv
module sdram_burst_engine
    import sbe_pkg::*;
#(
    parameter int COL_W  = 9,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cke,
    input  logic              mode_load,
    input  logic [MODE_W-1:0] mode_word,
    input  logic              cmd_rd,
    input  logic              cmd_wr,
    input  logic [COL_W-1:0]  cmd_col,
    input  logic [DATA_W-1:0] arr_rdata,
    output logic [COL_W-1:0]  col_addr,
    output logic              wr_stb,
    output logic              rd_oe,
    output logic [DATA_W-1:0] dq_out,
    output logic              pd_active
);

    logic   ien;
    phase_e phase;
    mode_t  mode_q;
    logic   take;
    logic   active;
    logic   is_rd;
    logic   pipe_busy;
    logic   cap_vld;

    assign take = ien && (cmd_rd || cmd_wr);

    always_ff @(posedge clk) begin
        if (rst)
            mode_q <= decode_mode('0);
        else if (ien && mode_load)
            mode_q <= decode_mode(mode_word);
    end

    sbe_cke_ctrl u_cke (
        .clk       (clk),
        .rst       (rst),
        .cke       (cke),
        .busy      (active || pipe_busy),
        .cmd_taken (take),
        .ien       (ien),
        .phase     (phase)
    );

    sbe_col_gen #(.COL_W(COL_W)) u_col (
        .clk       (clk),
        .rst       (rst),
        .ien       (ien),
        .start     (take),
        .start_rd  (cmd_rd),
        .start_col (cmd_col),
        .mode      (mode_q),
        .col       (col_addr),
        .active    (active),
        .is_rd     (is_rd)
    );

    assign cap_vld = ien && active && is_rd;
    assign wr_stb  = ien && active && !is_rd;

    sbe_lat_pipe #(.DATA_W(DATA_W), .DEPTH(CL_MAX)) u_pipe (
        .clk      (clk),
        .rst      (rst),
        .ien      (ien),
        .cap_vld  (cap_vld),
        .cap_data (arr_rdata),
        .cl       (mode_q.cl),
        .oe       (rd_oe),
        .dq       (dq_out),
        .busy     (pipe_busy)
    );

    assign pd_active = (phase == PH_PWRDN);

    // Power-down is only ever entered with no burst running.
    assert_pd_idle_R10: assert property (@(posedge clk) disable iff (rst)
        pd_active |-> !active);

endmodule

// File: tb/tb_sdram_burst_engine.sv
module tb_sdram_burst_engine;

    localparam int COL_W  = 9;
    localparam int DATA_W = 8;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              cke = 1'b1;
    logic              mode_load = 1'b0;
    logic [6:0]        mode_word = '0;
    logic              cmd_rd = 1'b0;
    logic              cmd_wr = 1'b0;
    logic [COL_W-1:0]  cmd_col = '0;
    logic [DATA_W-1:0] arr_rdata;
    logic [COL_W-1:0]  col_addr;
    logic              wr_stb;
    logic              rd_oe;
    logic [DATA_W-1:0] dq_out;
    logic              pd_active;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    assign arr_rdata = col_addr[7:0] ^ 8'h5A;

    sdram_burst_engine #(.COL_W(COL_W), .DATA_W(DATA_W)) dut (
        .clk       (clk),
        .rst       (rst),
        .cke       (cke),
        .mode_load (mode_load),
        .mode_word (mode_word),
        .cmd_rd    (cmd_rd),
        .cmd_wr    (cmd_wr),
        .cmd_col   (cmd_col),
        .arr_rdata (arr_rdata),
        .col_addr  (col_addr),
        .wr_stb    (wr_stb),
        .rd_oe     (rd_oe),
        .dq_out    (dq_out),
        .pd_active (pd_active)
    );

    task automatic step();
        @(posedge clk);
        #2;
    endtask

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic int exp_col(input int start, input int bl, input int il, input int i);
        int m;
        int lo;
        int off;
        m   = bl - 1;
        lo  = start & m;
        off = il ? ((lo ^ i) & m) : ((lo + i) & m);
        return (start & ~m) | off;
    endfunction

    task automatic set_mode(input int code, input int il, input int cl, input int ws);
        mode_word = {ws[0], cl[1:0], il[0], code[2:0]};
        mode_load = 1'b1;
        step();
        mode_load = 1'b0;
    endtask

    // Read with a per-edge mask of low cke samples; bit j is the sample at edge k+j.
    task automatic run_read(input int col, input int code, input int il, input int cl,
                            input logic [31:0] lowmask, input string req);
        int bl;
        int n;
        bl = 1 << code;
        n  = 0;
        cmd_rd  = 1'b1;
        cmd_col = COL_W'(col);
        cke     = !lowmask[0];
        step();
        cmd_rd = 1'b0;
        chk(req, "first column", int'(col_addr), exp_col(col, bl, il, 0));
        chk(req, "oe at command", int'(rd_oe), 0);
        for (int j = 1; j < 24; j++) begin
            cmd_wr  = lowmask[j-1];
            cmd_col = COL_W'(~col);
            cke     = !lowmask[j];
            step();
            cmd_wr = 1'b0;
            if (!lowmask[j-1]) n++;
            if (n < bl)
                chk(req, "column", int'(col_addr), exp_col(col, bl, il, n));
            chk(req, "rd_oe", int'(rd_oe), (n >= cl && n - cl < bl) ? 1 : 0);
            if (n >= cl && n - cl < bl)
                chk(req, "dq", int'(dq_out), (exp_col(col, bl, il, n - cl) & 8'hFF) ^ 8'h5A);
            chk(req, "no strobe on read", int'(wr_stb), 0);
        end
        cke = 1'b1;
        step();
        step();
    endtask

    task automatic run_write(input int col, input int code, input int il, input int ws,
                             input string req);
        int bl;
        int beats;
        bl    = 1 << code;
        beats = ws ? 1 : bl;
        cmd_wr  = 1'b1;
        cmd_col = COL_W'(col);
        step();
        cmd_wr = 1'b0;
        for (int j = 0; j <= beats; j++) begin
            chk(req, "wr_stb", int'(wr_stb), (j < beats) ? 1 : 0);
            if (j < beats)
                chk(req, "write column", int'(col_addr), exp_col(col, bl, il, j));
            step();
        end
    endtask

    task automatic t_reset();
        repeat (3) step();
        rst = 1'b0;
        step();
        chk("R12", "rd_oe", int'(rd_oe), 0);
        chk("R12", "wr_stb", int'(wr_stb), 0);
        chk("R12", "pd_active", int'(pd_active), 0);
        // Default: length 1, latency 2.
        run_read(9'h33, 0, 0, 2, 32'h0, "R12");
    endtask

    task automatic t_plain_reads();
        set_mode(2, 0, 2, 0);
        run_read(9'h0D, 2, 0, 2, 32'h0, "R1");
        set_mode(2, 1, 3, 0);
        run_read(9'h0D, 2, 1, 3, 32'h0, "R2");
        set_mode(3, 1, 2, 0);
        run_read(9'h12A, 3, 1, 2, 32'h0, "R3");
        set_mode(1, 0, 3, 0);
        run_read(9'h47, 1, 0, 3, 32'h0, "R1");
    endtask

    task automatic t_suspend_reads();
        set_mode(2, 0, 2, 0);
        run_read(9'h21, 2, 0, 2, 32'h2, "R4");
        run_read(9'h22, 2, 0, 2, 32'h4, "R6");
        run_read(9'h23, 2, 0, 2, 32'h1C, "R7");
        run_read(9'h25, 2, 0, 2, 32'h1, "R7");
        set_mode(3, 1, 3, 0);
        run_read(9'h36, 3, 1, 3, 32'h148, "R5");
    endtask

    task automatic t_writes();
        set_mode(2, 0, 2, 0);
        run_write(9'h31, 2, 0, 0, "R1");
        set_mode(3, 1, 2, 1);
        run_write(9'h5B, 3, 1, 1, "R8");
        run_read(9'h5B, 3, 1, 2, 32'h0, "R9");
    endtask

    task automatic t_write_suspend();
        set_mode(2, 0, 2, 0);
        cmd_wr  = 1'b1;
        cmd_col = 9'h31;
        step();
        cmd_wr = 1'b0;
        chk("R5", "beat0 strobe", int'(wr_stb), 1);
        cke = 1'b0;
        step();
        chk("R5", "strobe before frozen edge", int'(wr_stb), 0);
        chk("R4", "column at freeze", int'(col_addr), 9'h32);
        cke     = 1'b1;
        cmd_rd  = 1'b1;
        cmd_col = 9'h1F0;
        step();
        cmd_rd = 1'b0;
        chk("R7", "resumed strobe", int'(wr_stb), 1);
        chk("R5", "ignored read", int'(col_addr), 9'h32);
        step();
        chk("R7", "column 3", int'(col_addr), 9'h33);
        step();
        chk("R7", "wrapped column", int'(col_addr), 9'h30);
        chk("R7", "last strobe", int'(wr_stb), 1);
        step();
        chk("R7", "burst over", int'(wr_stb), 0);
    endtask

    task automatic t_truncate();
        set_mode(3, 0, 2, 0);
        cmd_rd  = 1'b1;
        cmd_col = 9'h40;
        step();
        cmd_rd = 1'b0;
        step();
        chk("R11", "old burst", int'(col_addr), 9'h41);
        cmd_rd  = 1'b1;
        cmd_col = 9'h53;
        step();
        cmd_rd = 1'b0;
        chk("R11", "new start", int'(col_addr), 9'h53);
        step();
        chk("R11", "new second", int'(col_addr), 9'h54);
        step();
        chk("R11", "new third", int'(col_addr), 9'h55);
        repeat (12) step();
    endtask

    task automatic t_powerdown();
        int seen;
        seen = 0;
        cke = 1'b0;
        step();
        chk("R10", "enter", int'(pd_active), 1);
        cmd_rd  = 1'b1;
        cmd_col = 9'h10;
        step();
        step();
        chk("R10", "stay", int'(pd_active), 1);
        cmd_rd = 1'b0;
        cke    = 1'b1;
        step();
        chk("R10", "exit", int'(pd_active), 0);
        for (int i = 0; i < 6; i++) begin
            step();
            if (rd_oe) seen++;
        end
        chk("R10", "no read started", seen, 0);
    endtask

    initial begin
        t_reset();
        t_plain_reads();
        t_suspend_reads();
        t_writes();
        t_write_suspend();
        t_truncate();
        t_powerdown();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule